// File: doc/BRIEF.md
# Prefix Register Loader with Thermometer Write Mask

This block holds a word of data in which a load overwrites only a low prefix of the bits. The length of that prefix is not kept as a binary number. It is held as a thermometer flag register: bit i is set exactly when position i belongs to the prefix. Each pulse of the grow strobe makes the prefix one position longer by shifting a one into the flag register. A pulse of the load strobe then copies the new word into every bit whose flag is set, and every other bit keeps its value.

The block is used in two phases. In the first, an outside controller pulses grow once per clock until its own stop condition is met. In the second, it pulses load to write the new word into the prefix. Each data bit has a two-way select between its held value and the new value, and that select is driven directly by its flag. No bit index is ever compared against a count. Data bits above the width of the flag register have no flag, so a load never writes them.

Top module: `prefix_load_reg`

## Requirements
- R1: A synchronous active-high reset clears every flag (prefix length 0) and clears the data register to zero.
- R2: After k grow cycles counted from reset, with k not above MASK_W, `mask_o` bit i is 1 exactly when i < k. Each grow cycle adds one set bit, and the new bit appears in the cycle after the strobe.
- R3: A grow strobe while all MASK_W flags are set leaves the mask at all ones. The mask does not wrap or clear.
- R4: On a load, every data bit whose flag is set takes the matching bit of `new_data_i`, visible on `data_o` in the next cycle.
- R5: On a load, every data bit whose flag is clear keeps its value. This covers bits at positions N to MASK_W-1 and all bits at MASK_W and above.
- R6: A load while the mask is all zeros leaves `data_o` unchanged.
- R7: When grow and load are both asserted in one cycle, the load uses the mask as it stood before that cycle's growth.
- R8: Without load, `data_o` holds its value. Without grow, `mask_o` holds its value.
- R9: The mask is always a thermometer code, with no set bit above a clear bit, and a set flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| grow_i | input | 1 | Extends the prefix by one position |
| load_i | input | 1 | Writes `new_data_i` into the flagged prefix |
| new_data_i | input | DATA_W | Word offered for loading |
| data_o | output | DATA_W | Registered data contents |
| mask_o | output | MASK_W | Registered thermometer flags (current prefix) |

## Verification
The bench builds the block with DATA_W = 12 and MASK_W = 7. This gives the largest prefix length of seven and also leaves five data bits that no flag covers. Seven grow steps are enough to reach saturation, so the bench can push grow past a full mask and confirm that it does not wrap. Because some bits lie above the mask, the bench can also confirm that an all-ones load leaves the uncovered upper bits untouched. A table walk covers a load with an empty mask, grow and load in the same cycle, and loads at partial and full prefix lengths. Directed steps then cover a reset in mid-operation and hold behaviour.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  // Default geometry: the longest prefix supported and the full word width.
  localparam int unsigned PFX_MAX_LEN = 7;
  localparam int unsigned PFX_WORD_W  = 16;

  // Control strobes sampled together each cycle.
  typedef struct packed {
    logic grow;
    logic load;
  } pfx_ctrl_t;
endpackage

// File: rtl/pfx_thermo_flags.sv
module pfx_thermo_flags #(
  parameter int unsigned MASK_W = pfx_pkg::PFX_MAX_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grow_i,
  output logic [MASK_W-1:0] flags_o
);
  logic [MASK_W-1:0] flags_q;
  logic [MASK_W-1:0] flags_shift;

  // Shifting a one into the bottom saturates by itself once the register is full.
  generate
    if (MASK_W == 1) begin : g_single
      assign flags_shift = 1'b1;
    end else begin : g_multi
      assign flags_shift = {flags_q[MASK_W-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (grow_i) begin
      flags_q <= flags_shift;
    end
  end

  assign flags_o = flags_q;

  AST_FLAGS_THERMO: assert property (@(posedge clk) disable iff (rst)
    ((flags_q & (flags_q + 1'b1)) == '0)); // R9
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R9
  AST_GROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (grow_i && !flags_q[MASK_W-1]) |=> ($countones(flags_q) == $countones($past(flags_q)) + 1)); // R2
  AST_GROW_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (grow_i && (&flags_q)) |=> (&flags_q)); // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !grow_i |=> $stable(flags_q)); // R8
endmodule

// File: rtl/pfx_data_bank.sv
module pfx_data_bank #(
  parameter int unsigned DATA_W = pfx_pkg::PFX_WORD_W,
  parameter int unsigned MASK_W = pfx_pkg::PFX_MAX_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [DATA_W-1:0] new_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] mask_ext;
  logic [DATA_W-1:0] data_q;

  // One cell per bit: a flag-driven 2:1 select feeding a register.
  // Cells above the flag width have no flag and never take new data.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_cell
      logic take;
      if (i < MASK_W) begin : g_flagged
        assign mask_ext[i] = mask_i[i];
      end else begin : g_fixed
        assign mask_ext[i] = 1'b0;
      end
      assign take = load_i & mask_ext[i];
      always_ff @(posedge clk) begin
        if (rst) begin
          data_q[i] <= 1'b0;
        end else if (take) begin
          data_q[i] <= new_i[i];
        end
      end
    end
  endgenerate

  assign data_o = data_q;

  AST_LOAD_TAKES_NEW: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ((data_q & $past(mask_ext)) == ($past(new_i) & $past(mask_ext)))); // R4
  AST_UNFLAGGED_HOLD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (((data_q ^ $past(data_q)) & ~$past(mask_ext)) == '0)); // R5
  AST_EMPTY_MASK_NOP: assert property (@(posedge clk) disable iff (rst)
    (load_i && (mask_i == '0)) |=> $stable(data_q)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(data_q)); // R8
endmodule

// File: rtl/prefix_load_reg.sv
module prefix_load_reg #(
  parameter int unsigned DATA_W = pfx_pkg::PFX_WORD_W,
  parameter int unsigned MASK_W = pfx_pkg::PFX_MAX_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grow_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] new_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [MASK_W-1:0] mask_o
);
  pfx_pkg::pfx_ctrl_t ctrl;
  logic [MASK_W-1:0]  flags;

  assign ctrl.grow = grow_i;
  assign ctrl.load = load_i;

  pfx_thermo_flags #(.MASK_W(MASK_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .grow_i  (ctrl.grow),
    .flags_o (flags)
  );

  // The bank sees the registered flags, i.e. the mask before this cycle's growth.
  pfx_data_bank #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .load_i (ctrl.load),
    .mask_i (flags),
    .new_i  (new_data_i),
    .data_o (data_o)
  );

  assign mask_o = flags;

  AST_CONCURRENT_OLD_MASK: assert property (@(posedge clk) disable iff (rst)
    (grow_i && load_i) |=> ((data_o & ~{{(DATA_W-MASK_W){1'b0}}, $past(mask_o)}) ==
                            ($past(data_o) & ~{{(DATA_W-MASK_W){1'b0}}, $past(mask_o)}))); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ((mask_o == '0) && (data_o == '0))); // R1
endmodule

// File: tb/tb_prefix_load_reg.sv
module tb_prefix_load_reg;
  localparam int DW = 12;
  localparam int MW = 7;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          grow_i = 1'b0;
  logic          load_i = 1'b0;
  logic [DW-1:0] new_data_i = '0;
  logic [DW-1:0] data_o;
  logic [MW-1:0] mask_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] ref_data;
  int            ref_n;

  always #2 clk = ~clk;

  prefix_load_reg #(.DATA_W(DW), .MASK_W(MW)) dut (
    .clk(clk), .rst(rst), .grow_i(grow_i), .load_i(load_i),
    .new_data_i(new_data_i), .data_o(data_o), .mask_o(mask_o)
  );

  // Vector: {grow, load, new data[11:0], expected prefix length after the step[2:0]}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b1, 12'hFFF, 3'd0},  // R6 load with empty mask
    {1'b1, 1'b0, 12'h000, 3'd1},  // R2
    {1'b1, 1'b1, 12'hFFF, 3'd2},  // R7 load sees length 1
    {1'b0, 1'b1, 12'hABE, 3'd2},  // R4/R5 partial prefix
    {1'b0, 1'b0, 12'h555, 3'd2},  // R8 idle
    {1'b1, 1'b0, 12'h000, 3'd3},
    {1'b1, 1'b0, 12'h000, 3'd4},
    {1'b0, 1'b1, 12'hF35, 3'd4},  // R4 length 4
    {1'b1, 1'b0, 12'h000, 3'd5},
    {1'b1, 1'b0, 12'h000, 3'd6},
    {1'b1, 1'b1, 12'h0C3, 3'd7},  // R7 load sees length 6
    {1'b1, 1'b0, 12'h000, 3'd7},  // R3 saturate
    {1'b1, 1'b0, 12'h000, 3'd7},  // R3 saturate
    {1'b0, 1'b1, 12'hFFF, 3'd7},  // R5 upper bits keep 0
    {1'b0, 1'b1, 12'h000, 3'd7},  // R4 clear the prefix
    {1'b0, 1'b0, 12'hFFF, 3'd7}   // R8 idle
  };

  function automatic logic [MW-1:0] therm(int n);
    logic [MW-1:0] m;
    for (int i = 0; i < MW; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [DW-1:0] ext(logic [MW-1:0] m);
    return {{(DW-MW){1'b0}}, m};
  endfunction

  task automatic check_mask(string req, logic [MW-1:0] exp);
    checks++;
    if (mask_o !== exp) begin
      fails++;
      $display("FAIL %s mask actual=%b expected=%b", req, mask_o, exp);
    end
  endtask

  task automatic check_data(string req, logic [DW-1:0] exp);
    checks++;
    if (data_o !== exp) begin
      fails++;
      $display("FAIL %s data actual=%h expected=%h", req, data_o, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(logic g, logic l, logic [DW-1:0] d);
    logic [MW-1:0] m_before;
    m_before   = therm(ref_n);
    grow_i     = g;
    load_i     = l;
    new_data_i = d;
    @(negedge clk);
    if (l) ref_data = (ref_data & ~ext(m_before)) | (d & ext(m_before));
    if (g && ref_n < MW) ref_n++;
    grow_i = 1'b0;
    load_i = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    ref_data = '0;
    ref_n    = 0;
    @(negedge clk);
    @(negedge clk);
    check_mask("R1", '0);
    check_data("R1", '0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][16], VEC[k][15], VEC[k][14:3]);
      check_mask("R2/R3/R9", therm(int'(VEC[k][2:0])));
      check_data("R4/R5/R6/R7/R8", ref_data);
    end
    // Upper uncovered bits after the all-ones load at full length.
    check_data("R5", ref_data & 12'h07F);

    // Reset in mid-operation clears both registers.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ref_data = '0;
    ref_n    = 0;
    check_mask("R1", '0);
    check_data("R1", '0);

    // Three grows, then an all-ones load: only bits 0..2 change.
    step(1'b1, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    check_mask("R2", 7'b0000111);
    step(1'b0, 1'b1, 12'hFFF);
    check_data("R4", 12'h007);
    check_data("R5", ref_data);

    // Idle cycles: neither register moves.
    step(1'b0, 1'b0, 12'hAAA);
    step(1'b0, 1'b0, 12'h555);
    check_mask("R8", 7'b0000111);
    check_data("R8", 12'h007);

    // Grow and load together at length 3: bit 3 must not be written.
    step(1'b1, 1'b1, 12'hFF8);
    check_data("R7", 12'h000);
    check_mask("R7", 7'b0001111);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule